// File: doc/BRIEF.md
# Windowed Watchdog Monitor

This block watches one service line driven by a processor and decides whether the processor is servicing it at a sane rate. Each high-to-low transition on the line is one service event. Two failures are caught. A service event that lands too soon after the last restart is an early fault. A silence that lasts as long as the selected upper limit is a late fault. Both produce a one-cycle fault pulse, which a reset sequencer elsewhere in the chip turns into a processor reset.

The service line comes from outside the clock domain, so it passes through a synchronizer before edge detection. The reset sequencer drives a "reset active" level back into the block. While that level is high the window counter stays at zero and every service edge is discarded. After release, counting starts at once. The first service event after each release is never judged early, but it still restarts the window. Monitoring cannot be switched off. A select input picks one of several early/late limit pairs, all held as parameters in clock cycles. The clock period must be shorter than the narrowest service pulse that has to be seen.

Top module: `wdw_monitor`

## Requirements
- R1: While `sup_rst_i` is high, `fault_o` stays low and the window counter is held at zero. Counting restarts from zero in the first cycle after `sup_rst_i` falls.
- R2: Falling edges on `kick_i` that are seen while `sup_rst_i` is high have no effect. They neither raise a fault nor change when the next late fault is due.
- R3: If no service event is processed, `fault_o` pulses in the cycle that follows the SLOW-th rising clock edge after the last restart. For example, the pulse follows the 100th edge for option 0.
- R4: A service event processed when fewer than FAST cycles have elapsed since the last restart raises `fault_o` in the following cycle. This does not apply to the first event after a release.
- R5: A service event processed when the elapsed cycle count is between FAST and SLOW-1 inclusive raises no fault and restarts the window. The bounds are counted as in R4 and R3, both bounds included.
- R6: The first service event after `sup_rst_i` falls is exempt from the early check, however soon it arrives. It still restarts the window.
- R7: `fault_o` is high for exactly one cycle per fault. The window counter restarts from zero after every fault, whether early or late.
- R8: The value of `win_sel_i` selects the (FAST, SLOW) pair in cycles. By default, 0 gives (15,100), 1 gives (30,200), 2 gives (24,44) and 3 gives (41,76).
- R9: A high-to-low change on `kick_i` is processed at the third rising clock edge after it is applied. That is two synchronizer flops plus one edge-detect flop. Its result shows on `fault_o` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; its period must be shorter than the shortest service pulse |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| kick_i | input | 1 | Asynchronous service line from the processor; a falling edge is one service event |
| sup_rst_i | input | 1 | High while the reset sequencer holds the processor in reset |
| win_sel_i | input | SEL_W | Selects one early/late limit pair |
| fault_o | output | 1 | One-cycle pulse on an early or late service fault |

## Verification
Timing differs by result. A late fault is due in the cycle after the SLOW-th rising edge that follows a restart. An early fault, or a restart caused by a service event, is due after the third rising edge that follows the change on `kick_i`. The fault from that event shows in the cycle after that edge. The bench counts rising edges from each release of `sup_rst_i`, drives every stimulus on a falling clock edge, and reads `fault_o` a short delay after the falling edge. Each check therefore compares the exact edge number of a fault against the number derived from these latencies. It also checks that no fault appears one cycle earlier.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

   // What the window counter does in a given cycle.
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,   // reset active: counter parked at zero
      ACT_COUNT = 2'd1,   // nothing happened: advance
      ACT_KICK  = 2'd2,   // service edge processed: restart window
      ACT_LATE  = 2'd3    // upper limit reached: fault and restart
   } wdw_act_e;

   // True when a counter value has run into the upper limit.
   function automatic logic limit_hit(input logic [31:0] elapsed,
                                      input logic [31:0] slow_cyc);
      return (elapsed + 32'd1) >= slow_cyc;
   endfunction

endpackage

// File: rtl/wdw_sync_edge.sv
module wdw_sync_edge #(
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wdw_sync_edge: STAGES must be at least 2");
   end

   // Synchronizer chain, one generate block per stage.
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stage_q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= IDLE;
            else        stage_q <= kick_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= IDLE;
            else        stage_q <= g_stage[g-1].stage_q;
         end
      end
   end

   logic synced;
   logic prev_q;

   assign synced = g_stage[STAGES-1].stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= synced;
   end

   assign fall_o = prev_q & ~synced;

   // R9: a detected fall lasts one cycle only
   assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/wdw_limits.sv
module wdw_limits #(
   parameter int unsigned N_OPT             = 4,
   parameter int unsigned SEL_W             = 2,
   parameter int unsigned CNT_W             = 16,
   parameter int unsigned FAST_CYC [N_OPT]  = '{15, 30, 24, 41},
   parameter int unsigned SLOW_CYC [N_OPT]  = '{100, 200, 44, 76}
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] fast_o,
   output logic [CNT_W-1:0] slow_o
);

   if (N_OPT < 1 || (64'd1 << SEL_W) < 64'(N_OPT)) begin : g_bad_sel
      $error("wdw_limits: SEL_W too narrow for N_OPT");
   end

   logic [CNT_W-1:0] fast_tbl [N_OPT];
   logic [CNT_W-1:0] slow_tbl [N_OPT];

   for (genvar g = 0; g < N_OPT; g++) begin : g_opt
      if (FAST_CYC[g] < 1 || FAST_CYC[g] >= SLOW_CYC[g]) begin : g_bad_order
         $error("wdw_limits: each option needs 1 <= FAST < SLOW");
      end
      if (64'(SLOW_CYC[g]) >= (64'd1 << CNT_W)) begin : g_bad_width
         $error("wdw_limits: SLOW limit does not fit CNT_W");
      end
      assign fast_tbl[g] = CNT_W'(FAST_CYC[g]);
      assign slow_tbl[g] = CNT_W'(SLOW_CYC[g]);
   end

   // Out-of-range codes fall back to option 0.
   always_comb begin
      fast_o = fast_tbl[0];
      slow_o = slow_tbl[0];
      for (int i = 0; i < N_OPT; i++) begin
         if (sel_i == SEL_W'(i)) begin
            fast_o = fast_tbl[i];
            slow_o = slow_tbl[i];
         end
      end
   end

endmodule

// File: rtl/wdw_window_ctr.sv
module wdw_window_ctr
   import wdw_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             fall_i,
   input  logic [CNT_W-1:0] fast_i,
   input  logic [CNT_W-1:0] slow_i,
   output logic             fault_o
);

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
      $error("wdw_window_ctr: CNT_W must lie in 2..31");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;   // set once the post-release edge was seen
   wdw_act_e         act;
   logic             early;

   always_comb begin
      if (hold_i)
         act = ACT_HOLD;
      else if (fall_i)
         act = ACT_KICK;
      else if (limit_hit(32'(cnt_q), 32'(slow_i)))
         act = ACT_LATE;
      else
         act = ACT_COUNT;
   end

   assign early = armed_q && (cnt_q < fast_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         fault_o <= 1'b0;
      end else begin
         unique case (act)
            ACT_HOLD: begin
               cnt_q   <= '0;
               armed_q <= 1'b0;
               fault_o <= 1'b0;
            end
            ACT_KICK: begin
               cnt_q   <= '0;
               armed_q <= 1'b1;
               fault_o <= early;
            end
            ACT_LATE: begin
               cnt_q   <= '0;
               fault_o <= 1'b1;
            end
            default: begin
               cnt_q   <= cnt_q + 1'b1;
               fault_o <= 1'b0;
            end
         endcase
      end
   end

   // R1: reset-active cycle leaves the counter parked and no fault
   assert_hold_parks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (cnt_q == '0 && !fault_o));

   // R7: a fault is one cycle wide
   assert_fault_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o);

   // R7: every fault comes with a restarted window
   assert_fault_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> cnt_q == '0);

   // R5: a processed edge restarts the window
   assert_kick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && fall_i) |=> cnt_q == '0);

   // R6: the first edge after release never faults
   assert_first_exempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && fall_i && !armed_q) |=> !fault_o);

endmodule

// File: rtl/wdw_monitor.sv
module wdw_monitor #(
   parameter int unsigned N_OPT            = 4,
   parameter int unsigned SEL_W            = 2,
   parameter int unsigned CNT_W            = 16,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter int unsigned FAST_CYC [N_OPT] = '{15, 30, 24, 41},
   parameter int unsigned SLOW_CYC [N_OPT] = '{100, 200, 44, 76}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick_i,
   input  logic             sup_rst_i,
   input  logic [SEL_W-1:0] win_sel_i,
   output logic             fault_o
);

   logic             fall;
   logic [CNT_W-1:0] fast_lim;
   logic [CNT_W-1:0] slow_lim;

   wdw_sync_edge #(
      .STAGES (SYNC_STAGES),
      .IDLE   (1'b1)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (kick_i),
      .fall_o (fall)
   );

   wdw_limits #(
      .N_OPT    (N_OPT),
      .SEL_W    (SEL_W),
      .CNT_W    (CNT_W),
      .FAST_CYC (FAST_CYC),
      .SLOW_CYC (SLOW_CYC)
   ) u_limits (
      .sel_i  (win_sel_i),
      .fast_o (fast_lim),
      .slow_o (slow_lim)
   );

   wdw_window_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_i  (sup_rst_i),
      .fall_i  (fall),
      .fast_i  (fast_lim),
      .slow_i  (slow_lim),
      .fault_o (fault_o)
   );

   // R1: no fault in the cycle after reset is seen active
   assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sup_rst_i |=> !fault_o);

endmodule

// File: tb/wdw_monitor_tb.sv
module wdw_monitor_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       kick_i = 1'b1;
   logic       sup_rst_i = 1'b1;
   logic [1:0] win_sel_i = 2'd0;
   logic       fault_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int t0     = 0;
   int nflt   = 0;
   int last_flt = -1;

   always #10 clk = ~clk;   // 50 MHz

   wdw_monitor u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_i    (kick_i),
      .sup_rst_i (sup_rst_i),
      .win_sel_i (win_sel_i),
      .fault_o   (fault_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (fault_o === 1'b1) begin
         nflt     = nflt + 1;
         last_flt = cyc;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Wait until n rising edges have passed since the last release, then
   // settle a little past the falling edge before reading.
   task automatic wait_until(input int n);
      while (cyc - t0 < n) @(negedge clk);
      #2;
   endtask

   task automatic release_sup();
      @(negedge clk);
      sup_rst_i = 1'b1;
      kick_i    = 1'b1;
      repeat (5) @(negedge clk);
      sup_rst_i = 1'b0;
      t0 = cyc;
   endtask

   task automatic drop_kick();
      kick_i = 1'b0;
      repeat (2) @(negedge clk);
      kick_i = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset_state();
      int n0;
      repeat (3) @(negedge clk);
      chk(fault_o == 1'b0, "R1 reset state", int'(fault_o), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         repeat (20) @(negedge clk);
         drop_kick();
      end
      repeat (80) @(negedge clk);
      chk(nflt == 0, "R1 R2 no fault while reset active", nflt, 0);
      n0 = nflt;
      sup_rst_i = 1'b0;
      t0 = cyc;
      wait_until(99);
      chk(nflt == n0, "R2 nothing early after edges in reset", nflt, n0);
      wait_until(100);
      chk(nflt == n0 + 1, "R3 late fault count", nflt, n0 + 1);
      chk(last_flt == t0 + 100, "R3 late fault edge", last_flt - t0, 100);
      wait_until(101);
      chk(fault_o == 1'b0, "R7 one cycle wide", int'(fault_o), 0);
      wait_until(200);
      chk(last_flt == t0 + 200, "R7 restart after late fault", last_flt - t0, 200);
      chk(nflt == n0 + 2, "R7 second late fault count", nflt, n0 + 2);
   endtask

   task automatic t_first_exempt();
      int n0;
      release_sup();
      n0 = nflt;
      drop_kick();                // processed at edge 3, elapsed 2
      wait_until(102);
      chk(nflt == n0, "R6 first edge not early", nflt, n0);
      wait_until(103);
      chk(last_flt == t0 + 103, "R6 first edge restarts window", last_flt - t0, 103);
   endtask

   task automatic t_early();
      int n0;
      release_sup();
      n0 = nflt;
      drop_kick();                // restart at edge 3
      wait_until(15);
      drop_kick();                // processed at edge 18, elapsed 14
      wait_until(18);
      chk(nflt == n0 + 1, "R4 early fault count", nflt, n0 + 1);
      chk(last_flt == t0 + 18, "R4 R9 early fault edge", last_flt - t0, 18);
      wait_until(117);
      chk(nflt == n0 + 1, "R7 no fault before restarted limit", nflt, n0 + 1);
      wait_until(118);
      chk(last_flt == t0 + 118, "R7 restart after early fault", last_flt - t0, 118);
   endtask

   task automatic t_bounds();
      int n0;
      release_sup();
      n0 = nflt;
      drop_kick();                // restart at edge 3
      wait_until(16);
      drop_kick();                // edge 19, elapsed 15 == FAST
      wait_until(116);
      drop_kick();                // edge 119, elapsed 99 == SLOW-1
      wait_until(218);
      chk(nflt == n0, "R5 edges at FAST and SLOW-1 accepted", nflt, n0);
      wait_until(219);
      chk(last_flt == t0 + 219, "R5 window restarted at edge 119", last_flt - t0, 219);
   endtask

   task automatic t_normal();
      int n0;
      release_sup();
      n0 = nflt;
      for (int k = 0; k < 6; k++) begin
         wait_until(k * 40);
         drop_kick();
      end
      wait_until(260);
      chk(nflt == n0, "R5 steady servicing", nflt, n0);
   endtask

   task automatic t_options();
      int n0;
      win_sel_i = 2'd2;
      release_sup();
      wait_until(44);
      chk(last_flt == t0 + 44, "R8 option 2 late limit", last_flt - t0, 44);
      release_sup();
      n0 = nflt;
      drop_kick();
      wait_until(23);
      drop_kick();                // edge 26, elapsed 22 < 24
      wait_until(26);
      chk(nflt == n0 + 1 && last_flt == t0 + 26, "R8 option 2 early limit", last_flt - t0, 26);
      release_sup();
      n0 = nflt;
      drop_kick();
      wait_until(24);
      drop_kick();                // edge 27, elapsed 23 < 24
      wait_until(30);
      chk(nflt == n0 + 1, "R8 option 2 early at FAST-1", nflt, n0 + 1);
      win_sel_i = 2'd3;
      release_sup();
      wait_until(76);
      chk(last_flt == t0 + 76, "R8 option 3 late limit", last_flt - t0, 76);
      win_sel_i = 2'd1;
      release_sup();
      n0 = nflt;
      wait_until(199);
      chk(nflt == n0, "R8 option 1 quiet before limit", nflt, n0);
      wait_until(200);
      chk(last_flt == t0 + 200, "R8 option 1 late limit", last_flt - t0, 200);
      win_sel_i = 2'd0;
   endtask

   task automatic t_mid_reset();
      int n0;
      release_sup();
      wait_until(60);
      n0 = nflt;
      sup_rst_i = 1'b1;
      repeat (6) @(negedge clk);
      chk(nflt == n0 && fault_o == 1'b0, "R1 mid-run reset quiet", nflt, n0);
      sup_rst_i = 1'b0;
      t0 = cyc;
      wait_until(99);
      chk(nflt == n0, "R1 counter restarted from zero", nflt, n0);
      wait_until(100);
      chk(last_flt == t0 + 100, "R1 late fault after re-release", last_flt - t0, 100);
   endtask

   initial begin
      t_reset_state();
      t_first_exempt();
      t_early();
      t_bounds();
      t_normal();
      t_options();
      t_mid_reset();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule